// File: doc/BRIEF.md
# Prioritised Bus Master Handover Arbiter

This block decides which agent drives a shared system bus. The host processor owns the bus by default. Two coprocessor channels may borrow it. Each channel asks for the bus with a request pulse and receives a one-clock grant pulse. Later it hands the bus back with a release pulse, and the bus then returns to the host.

The arbiter moves the bus only at a machine-cycle boundary. The host marks that boundary with an end-of-cycle strobe. An active-low lock input keeps the bus with the host while an atomic instruction runs. Requests are latched, so a short pulse waits until it can be served. When both channels are waiting, channel 0 wins.

The owner output uses this code: 0 means the host, 1 means channel 0 and 2 means channel 1. Grant bit k belongs to channel k.

Top module: `bus_handover_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, owner_o is 0 (host) and grant_o is 0. Requests latched before reset are discarded, so a strobe after reset grants nothing.
- R2: A single-cycle pulse on req_i[k] is held pending. The request is remembered until that channel is granted, even when the strobe comes many cycles later.
- R3: Suppose that in one cycle the host owns the bus, mc_end_i is 1, lock_n_i is 1 and some request is pending or arriving. Then in the next cycle grant_o is a one-hot pulse on the chosen channel, lasting exactly one clock. In that same cycle owner_o becomes that channel's code (k+1).
- R4: No grant is issued in a cycle that does not follow a cycle with mc_end_i at 1.
- R5: While lock_n_i is 0, a strobe causes no grant. The pending request is kept and is granted at the first strobe that finds lock_n_i at 1.
- R6: When both channels are pending at a granting strobe, channel 0 is granted first. Channel 1 stays pending.
- R7: While a coprocessor owns the bus, strobes and requests from the other channel cause no grant. The other request is served only after the bus has returned to the host and a later strobe occurs.
- R8: A release pulse from the owning channel sets owner_o to 0 in the next cycle. A strobe in the same cycle as that release grants nothing.
- R9: A release pulse from a channel that does not own the bus leaves owner_o and grant_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_i | input | 2 | Per-channel request pulses |
| rel_i | input | 2 | Per-channel release pulses |
| mc_end_i | input | 1 | Strobe from the host marking the last clock of a machine cycle |
| lock_n_i | input | 1 | Active-low lock; 0 blocks any handover |
| grant_o | output | 2 | Per-channel one-clock grant pulses |
| owner_o | output | 2 | Current bus owner: 0 host, 1 channel 0, 2 channel 1 |

## Verification
The assertions assume that all inputs change synchronously to the clock. They also assume that a channel never requests while it already holds the bus. Under these conditions a grant can always be traced back to the strobe cycle before it. The stimulus is applied on the falling edge. Requests come only from channels that do not own the bus. Strobes, locks and releases are placed in every combination the requirements mention, including strobes while a coprocessor owns the bus and releases that coincide with a strobe.

// File: rtl/bha_pkg.sv
package bha_pkg;
  parameter int unsigned NUM_CH = 2;
  localparam int unsigned OWN_W = $clog2(NUM_CH + 1);
  typedef logic [OWN_W-1:0] owner_t;
  localparam owner_t OWNER_HOST = '0;
endpackage

// File: rtl/bha_req_latch.sv
module bha_req_latch #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar k = 0; k < N; k++) begin : g_ch
    logic pend_q;
    logic pend_d;
    logic pend_en;

    always_comb begin
      pend_en = set_i[k] | clr_i[k];
      pend_d  = set_i[k] & ~clr_i[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
      end else if (pend_en) begin
        pend_q <= pend_d;
      end
    end

    assign pend_o[k] = pend_q;
  end
endmodule

// File: rtl/bha_prio_pick.sv
module bha_prio_pick #(
  parameter int unsigned N = 2
) (
  input  logic [N-1:0] cand_i,
  output logic [N-1:0] pick_o,
  output logic         any_o
);
  always_comb begin
    pick_o = cand_i & (~cand_i + {{(N-1){1'b0}}, 1'b1});
    any_o  = |cand_i;
  end
endmodule

// File: rtl/bha_owner_ctl.sv
module bha_owner_ctl
  import bha_pkg::*;
#(
  parameter int unsigned N = NUM_CH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mc_end_i,
  input  logic         lock_n_i,
  input  logic [N-1:0] pick_i,
  input  logic         pick_any_i,
  input  logic [N-1:0] rel_i,
  output logic [N-1:0] grant_d_o,
  output logic [N-1:0] grant_o,
  output owner_t       owner_o
);
  owner_t       owner_q, owner_d, pick_code;
  logic [N-1:0] grant_q;
  logic         host_owns, handover, rel_hit, owner_en;

  always_comb begin
    pick_code = OWNER_HOST;
    rel_hit   = 1'b0;
    for (int k = 0; k < int'(N); k++) begin
      if (pick_i[k]) pick_code = owner_t'(k + 1);
      if (owner_q == owner_t'(k + 1) && rel_i[k]) rel_hit = 1'b1;
    end
    host_owns = (owner_q == OWNER_HOST);
    handover  = host_owns & mc_end_i & lock_n_i & pick_any_i;
    owner_en  = handover | rel_hit;
    owner_d   = handover ? pick_code : OWNER_HOST;
    grant_d_o = handover ? pick_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= OWNER_HOST;
      grant_q <= '0;
    end else begin
      grant_q <= grant_d_o;
      if (owner_en) begin
        owner_q <= owner_d;
      end
    end
  end

  assign owner_o = owner_q;
  assign grant_o = grant_q;
endmodule

// File: rtl/bus_handover_arbiter.sv
module bus_handover_arbiter
  import bha_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   req_i,
  input  logic [NUM_CH-1:0]   rel_i,
  input  logic                mc_end_i,
  input  logic                lock_n_i,
  output logic [NUM_CH-1:0]   grant_o,
  output logic [OWN_W-1:0]    owner_o
);
  logic [NUM_CH-1:0] own_mask, req_set, pend, cand, pick, grant_d;
  logic              pick_any;
  owner_t            owner;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_mask
    assign own_mask[k] = (owner == owner_t'(k + 1));
  end

  assign req_set = req_i & ~own_mask;
  assign cand    = pend | req_set;

  bha_req_latch #(.N(NUM_CH)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (req_set),
    .clr_i  (grant_d),
    .pend_o (pend)
  );

  bha_prio_pick #(.N(NUM_CH)) u_pick (
    .cand_i (cand),
    .pick_o (pick),
    .any_o  (pick_any)
  );

  bha_owner_ctl #(.N(NUM_CH)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mc_end_i   (mc_end_i),
    .lock_n_i   (lock_n_i),
    .pick_i     (pick),
    .pick_any_i (pick_any),
    .rel_i      (rel_i),
    .grant_d_o  (grant_d),
    .grant_o    (grant_o),
    .owner_o    (owner)
  );

  assign owner_o = owner;
endmodule

// File: rtl/bha_checker.sv
module bha_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] req_i,
  input logic [1:0] rel_i,
  input logic       mc_end_i,
  input logic       lock_n_i,
  input logic [1:0] grant_o,
  input logic [1:0] owner_o
);
  logic own_rel;
  assign own_rel = (owner_o == 2'd1 && rel_i[0]) || (owner_o == 2'd2 && rel_i[1]);

  p_reset_host_r1: assert property (@(posedge clk)
    !rst_n |-> (owner_o == 2'd0 && grant_o == 2'b00));

  p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  p_grant_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != 2'b00) |-> (owner_o == {grant_o[1], grant_o[0]} && $past(owner_o) == 2'd0));

  p_grant_after_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != 2'b00) |-> $past(mc_end_i));

  p_lock_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != 2'b00) |-> $past(lock_n_i));

  p_ch0_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o[1] |-> !$past(req_i[0]));

  p_hold_while_owned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_o != 2'd0 && !own_rel) |=> ($stable(owner_o) && grant_o == 2'b00));

  p_release_returns_r8: assert property (@(posedge clk) disable iff (!rst_n)
    own_rel |=> (owner_o == 2'd0 && grant_o == 2'b00));

  p_foreign_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_o == 2'd1 && rel_i == 2'b10) |=> (owner_o == 2'd1));
endmodule

bind bus_handover_arbiter bha_checker u_bha_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_i    (req_i),
  .rel_i    (rel_i),
  .mc_end_i (mc_end_i),
  .lock_n_i (lock_n_i),
  .grant_o  (grant_o),
  .owner_o  (owner_o)
);

// File: tb/bus_handover_arbiter_bench.sv
module bus_handover_arbiter_bench;
  logic       clk;
  logic       rst_n;
  logic [1:0] req_i, rel_i;
  logic       mc_end_i, lock_n_i;
  logic [1:0] grant_o, owner_o;

  int n_chk;
  int n_bad;
  bit done;

  bus_handover_arbiter u_bus_handover_arbiter (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .rel_i    (rel_i),
    .mc_end_i (mc_end_i),
    .lock_n_i (lock_n_i),
    .grant_o  (grant_o),
    .owner_o  (owner_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {req, rel, mc_end, lock_n, expected grant, expected owner}
  localparam int NV = 21;
  localparam logic [9:0] VEC [NV] = '{
    {2'b01, 2'b00, 1'b0, 1'b1, 2'b00, 2'd0},
    {2'b00, 2'b00, 1'b0, 1'b1, 2'b00, 2'd0},
    {2'b00, 2'b00, 1'b1, 1'b1, 2'b01, 2'd1},
    {2'b00, 2'b00, 1'b0, 1'b1, 2'b00, 2'd1},
    {2'b00, 2'b00, 1'b1, 1'b1, 2'b00, 2'd1},
    {2'b10, 2'b00, 1'b0, 1'b1, 2'b00, 2'd1},
    {2'b00, 2'b10, 1'b0, 1'b1, 2'b00, 2'd1},
    {2'b00, 2'b01, 1'b0, 1'b1, 2'b00, 2'd0},
    {2'b00, 2'b00, 1'b1, 1'b0, 2'b00, 2'd0},
    {2'b00, 2'b00, 1'b1, 1'b1, 2'b10, 2'd2},
    {2'b00, 2'b10, 1'b0, 1'b1, 2'b00, 2'd0},
    {2'b11, 2'b00, 1'b1, 1'b1, 2'b01, 2'd1},
    {2'b00, 2'b01, 1'b0, 1'b1, 2'b00, 2'd0},
    {2'b00, 2'b00, 1'b1, 1'b1, 2'b10, 2'd2},
    {2'b00, 2'b10, 1'b0, 1'b1, 2'b00, 2'd0},
    {2'b10, 2'b00, 1'b0, 1'b0, 2'b00, 2'd0},
    {2'b00, 2'b00, 1'b1, 1'b0, 2'b00, 2'd0},
    {2'b00, 2'b00, 1'b0, 1'b1, 2'b00, 2'd0},
    {2'b00, 2'b00, 1'b1, 1'b1, 2'b10, 2'd2},
    {2'b00, 2'b10, 1'b1, 1'b1, 2'b00, 2'd0},
    {2'b00, 2'b00, 1'b1, 1'b1, 2'b00, 2'd0}
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 1:          return "R2";
      2:             return "R3";
      3:             return "R4";
      4, 5:          return "R7";
      6:             return "R9";
      7, 10, 12, 14: return "R8";
      8, 16, 17:     return "R5";
      9, 13:         return "R7";
      11:            return "R6";
      15:            return "R5";
      18:            return "R5";
      19:            return "R8";
      default:       return "R4";
    endcase
  endfunction

  task automatic check(string tag, logic [1:0] exp_g, logic [1:0] exp_o);
    n_chk++;
    if (grant_o !== exp_g || owner_o !== exp_o) begin
      n_bad++;
      $display("FAIL %s: grant=%b owner=%0d, expected grant=%b owner=%0d",
               tag, grant_o, owner_o, exp_g, exp_o);
    end
  endtask

  task automatic drive(logic [1:0] rq, logic [1:0] rl, logic mc, logic ln);
    req_i    = rq;
    rel_i    = rl;
    mc_end_i = mc;
    lock_n_i = ln;
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    drive(2'b00, 2'b00, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    check("R1", 2'b00, 2'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 2'b00, 2'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][9:8], VEC[i][7:6], VEC[i][5], VEC[i][4]);
      @(negedge clk);
      check(vec_tag(i), VEC[i][3:2], VEC[i][1:0]);
    end

    // R2: a request held over many idle cycles is still granted at the strobe
    drive(2'b10, 2'b00, 1'b0, 1'b1);
    @(negedge clk);
    drive(2'b00, 2'b00, 1'b0, 1'b1);
    repeat (12) @(negedge clk);
    drive(2'b00, 2'b00, 1'b1, 1'b1);
    @(negedge clk);
    check("R2", 2'b10, 2'd2);
    drive(2'b00, 2'b10, 1'b0, 1'b1);
    @(negedge clk);
    check("R8", 2'b00, 2'd0);

    // R1: reset while a coprocessor owns the bus
    drive(2'b01, 2'b00, 1'b1, 1'b1);
    @(negedge clk);
    check("R3", 2'b01, 2'd1);
    drive(2'b10, 2'b00, 1'b0, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", 2'b00, 2'd0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(2'b00, 2'b00, 1'b1, 1'b1);
    @(negedge clk);
    check("R1", 2'b00, 2'd0);
    drive(2'b00, 2'b00, 1'b0, 1'b1);
    @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule